// File: doc/BRIEF.md
# Fractional-N PLL Setting Calculator

This block turns two rates, the reference clock rate feeding a fractional-N PLL and the rate wanted at its output, into a full set of PLL settings. The settings are the reference pre-divider, the integer feedback multiplier, an 18-bit fractional feedback multiplier, the output post-divider and the sigma-delta control value. It also reports the rates these settings produce: the comparison frequency (fint), the DCO rate and the output rate. The settings are then packed into the bit fields of four 32-bit configuration words, ready for a bus master elsewhere to write.

Requests arrive on a valid/ready input. `in_ready` is high only while the block is idle. A request is taken on a rising edge where both `in_valid` and `in_ready` are high. While a request is being worked on, `in_ready` stays low and anything offered on `in_valid` is dropped, not queued. The output side has no back-pressure: `out_valid` is high for exactly one cycle, and the results then stay on the outputs until the next request is taken. A single shared iterative divider performs every division in turn, so each request takes a fixed number of cycles.

Hardware limits are parameters: the largest fint (`FINT_MAX`), the lowest DCO rate (`DCO_MIN`), the DCO band threshold (`DCO_LOW`) and the sigma-delta step (`SD_STEP`). Both input rates must be nonzero.

Top module: `fpll_calc`

## Requirements
- R1: While reset is held, and right after it, `in_ready` is 1, `out_valid` is 0, and `out_n`, `out_m` and `out_mf` are 0.
- R2: `out_n` is ceil(clkin / FINT_MAX), and `out_fint` is floor(clkin / out_n). A clkin that is an exact multiple of FINT_MAX gives no extra count.
- R3: `out_m2` is ceil(mind / target), and is forced to 1 if that gives 0. Here mind is DCO_MIN rounded up to the next multiple of fint.
- R4: `out_m` is floor(target × m2 / fint), saturated at 2^MW − 1.
- R5: Let res = target × m2 − fint × m. If res exceeds fint, `out_mf` is 0 and `out_warn` is 1. Otherwise `out_mf` is floor(262144 × res / fint) and `out_warn` is 0.
- R6: `out_dco` is fint × m + floor(mf × fint / 262144), and `out_clkout` is floor(dco / m2).
- R7: `out_sd` is ceil(fint × m / SD_STEP).
- R8: Packing into the configuration words:
  - `out_cfg1` holds m in bits [20:9] and n − 1 in bits [8:1].
  - `out_cfg3` holds sd in bits [17:10].
  - `out_cfg4` holds m2 in bits [24:18] and mf in bits [17:0].
  - All other bits of these words are 0.
- R9: `out_cfg2` bits [3:1] hold 4 when the DCO rate is strictly above DCO_LOW, and 2 otherwise. Its other bits are 0.
- R10: While a request is in progress, `in_ready` is 0 and `in_valid` has no effect. The results delivered are those of the request that was taken.
- R11: `out_valid` is high for exactly one cycle, after the 529th rising edge that follows the edge that took the request (8 × (2·VW + 2) + 1 edges with VW = 32). The results hold in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request may be taken |
| in_clkin | input | VW | Reference clock rate in Hz |
| in_target | input | VW | Wanted output rate in Hz |
| out_valid | output | 1 | One-cycle pulse: results are ready |
| out_n | output | VW | Pre-divider |
| out_fint | output | VW | Comparison frequency |
| out_m | output | MW | Integer multiplier |
| out_mf | output | 18 | Fractional multiplier |
| out_m2 | output | VW | Post-divider |
| out_sd | output | VW | Sigma-delta value |
| out_dco | output | VW | Resulting DCO rate |
| out_clkout | output | VW | Resulting output rate |
| out_warn | output | 1 | Residual too large; mf forced to 0 |
| out_cfg1 | output | 32 | Packed word with m and n − 1 |
| out_cfg2 | output | 32 | Packed word with the DCO band code |
| out_cfg3 | output | 32 | Packed word with sd |
| out_cfg4 | output | 32 | Packed word with m2 and mf |

## Verification
Eight divisions run back to back. Each one takes 66 cycles: one cycle to launch, 64 iteration steps, and one cycle to capture the result. After the last division, one more edge raises `out_valid`, so the result pulse is due on the 529th edge after the request is taken. The bench drives and samples on falling edges and counts rising edges from the accepting edge. It checks that the pulse appears on exactly that count. At the pulse it compares every result against a reference computed in the bench. One cycle later it confirms that the pulse has dropped and that the results still hold. During a request, a competing request is offered and the bench confirms that `in_ready` stays low.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
  // Fraction resolution of the feedback multiplier.
  localparam int FRAC_BITS = 18;

  // Field placement inside the configuration words.
  localparam int F1_M_LSB   = 9;
  localparam int F1_M_W     = 12;
  localparam int F1_N_LSB   = 1;
  localparam int F1_N_W     = 8;
  localparam int F2_SEL_LSB = 1;
  localparam int F2_SEL_W   = 3;
  localparam int F3_SD_LSB  = 10;
  localparam int F3_SD_W    = 8;
  localparam int F4_M2_LSB  = 18;
  localparam int F4_M2_W    = 7;
  localparam int F4_MF_LSB  = 0;

  // Band codes for the DCO frequency-select field.
  localparam logic [2:0] SEL_HIGH = 3'd4;
  localparam logic [2:0] SEL_LOW  = 3'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_N, ST_FINT, ST_MIND, ST_M2, ST_M, ST_MF, ST_OUT, ST_SD, ST_DONE
  } fpll_state_e;
endpackage

// File: rtl/fpll_div.sv
// Iterative restoring divider: one quotient bit per cycle.
module fpll_div #(
  parameter int DW = 64,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [VW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvd_q, quot_q, orig_q;
  logic [VW-1:0] dvs_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [VW:0]   trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem_q, dvd_q[DW-1]};
    ge    = trial >= {1'b0, dvs_q};
    diff  = trial - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      quot_q <= '0;
      orig_q <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dvd_q  <= dividend;
        orig_q <= dividend;
        dvs_q  <= divisor;
        quot_q <= '0;
        rem_q  <= '0;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q  <= dvd_q << 1;
        quot_q <= {quot_q[DW-2:0], ge};
        rem_q  <= ge ? diff[VW-1:0] : trial[VW-1:0];
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quot = quot_q;
  assign rem  = rem_q;

  // R2 (every quotient the block uses): the result reconstructs the dividend.
  a_r2_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |->
      ((DW+VW)'(quot_q) * (DW+VW)'(dvs_q) + (DW+VW)'(rem_q) == (DW+VW)'(orig_q))
      && (rem_q < dvs_q));
endmodule

// File: rtl/fpll_seq.sv
// Sequencer: issues the eight divisions in order and derives each setting.
module fpll_seq import fpll_pkg::*; #(
  parameter int              VW       = 32,
  parameter int              MW       = 12,
  parameter longint unsigned FINT_MAX = 2_500_000,
  parameter longint unsigned DCO_MIN  = 500_000_000,
  parameter longint unsigned SD_STEP  = 250_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VW-1:0]   in_clkin,
  input  logic [VW-1:0]   in_target,
  output logic            div_start,
  output logic [2*VW-1:0] div_dividend,
  output logic [VW-1:0]   div_divisor,
  input  logic            div_done,
  input  logic [2*VW-1:0] div_quot,
  input  logic [VW-1:0]   div_rem,
  output logic            out_valid,
  output logic [VW-1:0]   n_o,
  output logic [VW-1:0]   fint_o,
  output logic [MW-1:0]   m_o,
  output logic [FRAC_BITS-1:0] mf_o,
  output logic [VW-1:0]   m2_o,
  output logic [VW-1:0]   sd_o,
  output logic [2*VW-1:0] dco_o,
  output logic [VW-1:0]   clkout_o,
  output logic            warn_o
);
  localparam int DW = 2 * VW;
  localparam logic [MW-1:0] M_MAX = '1;

  fpll_state_e state_q;
  logic          launch_q, valid_q, warn_q;
  logic [VW-1:0] clk_q, tgt_q, n_q, fint_q, m2_q, sd_q, out_q;
  logic [MW-1:0] m_q;
  logic [FRAC_BITS-1:0] mf_q;
  logic [DW-1:0] mind_q, tdco_q, res_q, dco_q;

  logic [DW-1:0] ceil_v, res_v, fm_v, dco_v;
  logic [VW-1:0] m2_v;
  logic [MW-1:0] m_v;
  logic [FRAC_BITS-1:0] mf_v;

  always_comb begin
    ceil_v = div_quot + DW'(div_rem != '0);
    m2_v   = (ceil_v == '0) ? VW'(1) : ceil_v[VW-1:0];
    m_v    = (div_quot > DW'(M_MAX)) ? M_MAX : div_quot[MW-1:0];
    res_v  = tdco_q - DW'(fint_q) * DW'(m_v);
    fm_v   = DW'(fint_q) * DW'(m_q);
    mf_v   = warn_q ? '0 : div_quot[FRAC_BITS-1:0];
    dco_v  = fm_v + ((DW'(mf_v) * DW'(fint_q)) >> FRAC_BITS);
  end

  always_comb begin
    div_dividend = '0;
    div_divisor  = VW'(1);
    case (state_q)
      ST_N:    begin div_dividend = DW'(clk_q);        div_divisor = VW'(FINT_MAX); end
      ST_FINT: begin div_dividend = DW'(clk_q);        div_divisor = n_q;           end
      ST_MIND: begin div_dividend = DW'(DCO_MIN);      div_divisor = fint_q;        end
      ST_M2:   begin div_dividend = mind_q;            div_divisor = tgt_q;         end
      ST_M:    begin div_dividend = tdco_q;            div_divisor = fint_q;        end
      ST_MF:   begin div_dividend = res_q << FRAC_BITS; div_divisor = fint_q;       end
      ST_OUT:  begin div_dividend = dco_q;             div_divisor = m2_q;          end
      ST_SD:   begin div_dividend = fm_v;              div_divisor = VW'(SD_STEP);  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      launch_q <= 1'b0; valid_q <= 1'b0; warn_q <= 1'b0;
      clk_q <= '0; tgt_q <= '0; n_q <= '0; fint_q <= '0; m2_q <= '0;
      sd_q <= '0; out_q <= '0; m_q <= '0; mf_q <= '0;
      mind_q <= '0; tdco_q <= '0; res_q <= '0; dco_q <= '0;
    end else begin
      launch_q <= 1'b0;
      valid_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (in_valid) begin
          clk_q <= in_clkin;
          tgt_q <= in_target;
          launch_q <= 1'b1;
          state_q <= ST_N;
        end
        ST_DONE: begin
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: if (div_done) begin
          launch_q <= 1'b1;
          case (state_q)
            ST_N:    begin n_q <= ceil_v[VW-1:0]; state_q <= ST_FINT; end
            ST_FINT: begin fint_q <= div_quot[VW-1:0]; state_q <= ST_MIND; end
            ST_MIND: begin mind_q <= ceil_v * DW'(fint_q); state_q <= ST_M2; end
            ST_M2: begin
              m2_q <= m2_v;
              tdco_q <= DW'(tgt_q) * DW'(m2_v);
              state_q <= ST_M;
            end
            ST_M: begin
              m_q <= m_v;
              res_q <= res_v;
              warn_q <= res_v > DW'(fint_q);
              state_q <= ST_MF;
            end
            ST_MF:  begin mf_q <= mf_v; dco_q <= dco_v; state_q <= ST_OUT; end
            ST_OUT: begin out_q <= div_quot[VW-1:0]; state_q <= ST_SD; end
            ST_SD: begin
              sd_q <= ceil_v[VW-1:0];
              launch_q <= 1'b0;
              state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign div_start = launch_q;
  assign out_valid = valid_q;
  assign n_o = n_q;       assign fint_o = fint_q;  assign m_o = m_q;
  assign mf_o = mf_q;     assign m2_o = m2_q;      assign sd_o = sd_q;
  assign dco_o = dco_q;   assign clkout_o = out_q; assign warn_o = warn_q;

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(clk_q) && $stable(tgt_q)));
  a_r3_m2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (m2_q != '0));
  a_r5_warn_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && warn_q) |-> (mf_q == '0));
  a_r6_dco_floor: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (dco_q >= DW'(fint_q) * DW'(m_q)));
endmodule

// File: rtl/fpll_pack.sv
// Places the settings into the configuration word fields.
module fpll_pack import fpll_pkg::*; #(
  parameter int              VW      = 32,
  parameter int              MW      = 12,
  parameter longint unsigned DCO_LOW = 1_000_000_000
) (
  input  logic [VW-1:0]        n,
  input  logic [MW-1:0]        m,
  input  logic [VW-1:0]        m2,
  input  logic [FRAC_BITS-1:0] mf,
  input  logic [VW-1:0]        sd,
  input  logic [2*VW-1:0]      dco,
  output logic [31:0]          cfg1,
  output logic [31:0]          cfg2,
  output logic [31:0]          cfg3,
  output logic [31:0]          cfg4
);
  always_comb begin
    cfg1 = '0;
    cfg2 = '0;
    cfg3 = '0;
    cfg4 = '0;
    cfg1[F1_M_LSB +: F1_M_W]     = F1_M_W'(m);
    cfg1[F1_N_LSB +: F1_N_W]     = F1_N_W'(n - VW'(1));
    cfg2[F2_SEL_LSB +: F2_SEL_W] = (dco > (2*VW)'(DCO_LOW)) ? SEL_HIGH : SEL_LOW;
    cfg3[F3_SD_LSB +: F3_SD_W]   = F3_SD_W'(sd);
    cfg4[F4_M2_LSB +: F4_M2_W]   = F4_M2_W'(m2);
    cfg4[F4_MF_LSB +: FRAC_BITS] = mf;
  end
endmodule

// File: rtl/fpll_calc.sv
module fpll_calc import fpll_pkg::*; #(
  parameter int              VW       = 32,
  parameter int              MW       = 12,
  parameter longint unsigned FINT_MAX = 2_500_000,
  parameter longint unsigned DCO_MIN  = 500_000_000,
  parameter longint unsigned DCO_LOW  = 1_000_000_000,
  parameter longint unsigned SD_STEP  = 250_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [VW-1:0]        in_clkin,
  input  logic [VW-1:0]        in_target,
  output logic                 out_valid,
  output logic [VW-1:0]        out_n,
  output logic [VW-1:0]        out_fint,
  output logic [MW-1:0]        out_m,
  output logic [FRAC_BITS-1:0] out_mf,
  output logic [VW-1:0]        out_m2,
  output logic [VW-1:0]        out_sd,
  output logic [VW-1:0]        out_dco,
  output logic [VW-1:0]        out_clkout,
  output logic                 out_warn,
  output logic [31:0]          out_cfg1,
  output logic [31:0]          out_cfg2,
  output logic [31:0]          out_cfg3,
  output logic [31:0]          out_cfg4
);
  localparam int DW = 2 * VW;

  logic          div_start, div_done;
  logic [DW-1:0] div_dividend, div_quot, dco_full;
  logic [VW-1:0] div_divisor, div_rem;

  fpll_div #(.DW(DW), .VW(VW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_dividend), .divisor(div_divisor),
    .done(div_done), .quot(div_quot), .rem(div_rem)
  );

  fpll_seq #(.VW(VW), .MW(MW), .FINT_MAX(FINT_MAX), .DCO_MIN(DCO_MIN),
             .SD_STEP(SD_STEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_clkin(in_clkin), .in_target(in_target),
    .div_start(div_start), .div_dividend(div_dividend), .div_divisor(div_divisor),
    .div_done(div_done), .div_quot(div_quot), .div_rem(div_rem),
    .out_valid(out_valid), .n_o(out_n), .fint_o(out_fint), .m_o(out_m),
    .mf_o(out_mf), .m2_o(out_m2), .sd_o(out_sd), .dco_o(dco_full),
    .clkout_o(out_clkout), .warn_o(out_warn)
  );

  fpll_pack #(.VW(VW), .MW(MW), .DCO_LOW(DCO_LOW)) u_pack (
    .n(out_n), .m(out_m), .m2(out_m2), .mf(out_mf), .sd(out_sd), .dco(dco_full),
    .cfg1(out_cfg1), .cfg2(out_cfg2), .cfg3(out_cfg3), .cfg4(out_cfg4)
  );

  assign out_dco = dco_full[VW-1:0];
endmodule

// File: tb/fpll_calc_tb.sv
`timescale 1ns/100ps
module fpll_calc_tb;
  localparam longint FM   = 2_500_000;
  localparam longint DMIN = 500_000_000;
  localparam longint DLOW = 1_000_000_000;
  localparam longint STEP = 250_000_000;
  localparam longint MMAX = 4095;
  localparam longint MSK  = 64'hFFFF_FFFF;
  localparam int     LAT  = 8 * (2 * 32 + 2) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_clkin = '0, in_target = '0;
  logic in_ready, out_valid, out_warn;
  logic [31:0] out_n, out_fint, out_m2, out_sd, out_dco, out_clkout;
  logic [11:0] out_m;
  logic [17:0] out_mf;
  logic [31:0] out_cfg1, out_cfg2, out_cfg3, out_cfg4;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpll_calc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_clkin(in_clkin), .in_target(in_target), .out_valid(out_valid),
    .out_n(out_n), .out_fint(out_fint), .out_m(out_m), .out_mf(out_mf),
    .out_m2(out_m2), .out_sd(out_sd), .out_dco(out_dco), .out_clkout(out_clkout),
    .out_warn(out_warn), .out_cfg1(out_cfg1), .out_cfg2(out_cfg2),
    .out_cfg3(out_cfg3), .out_cfg4(out_cfg4)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", 64'(in_ready), 1);
    chk("R1 out_valid in reset", 64'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", 64'(in_ready), 1);
    chk("R1 out_valid after reset", 64'(out_valid), 0);
    chk("R1 out_n zero", 64'(out_n), 0);
    chk("R1 out_m zero", 64'(out_m), 0);
    chk("R1 out_mf zero", 64'(out_mf), 0);
  endtask

  task automatic run_case(input string name, input longint ck, input longint tg,
                          input bit intrude);
    longint n, fint, mind, m2, tdco, m, res, mf, dco, cko, sd, sel, warn;
    int k;
    n = (ck + FM - 1) / FM;
    fint = ck / n;
    mind = ((DMIN + fint - 1) / fint) * fint;
    m2 = (mind + tg - 1) / tg;
    if (m2 == 0) m2 = 1;
    tdco = tg * m2;
    m = tdco / fint;
    if (m > MMAX) m = MMAX;
    res = tdco - fint * m;
    if (res > fint) begin mf = 0; warn = 1; end
    else begin mf = (res * 262144) / fint; warn = 0; end
    dco = fint * m + (mf * fint) / 262144;
    cko = (dco / m2) & MSK;
    sd = (fint * m + STEP - 1) / STEP;
    sel = (dco > DLOW) ? 4 : 2;

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_clkin = 32'(ck); in_target = 32'(tg);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 0;
    while (k < 2000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (intrude && k == 5) begin
        chk({"R10 in_ready low while busy ", name}, 64'(in_ready), 0);
        in_valid = 1'b1; in_clkin = 32'd26_000_000; in_target = 32'd7_000_001;
      end
      if (intrude && k == 40) in_valid = 1'b0;
      if (out_valid) break;
    end
    chk({"R11 latency ", name}, 64'(k), 64'(LAT));
    chk({"R2 n ", name}, 64'(out_n), n);
    chk({"R2 fint ", name}, 64'(out_fint), fint);
    chk({"R3 m2 ", name}, 64'(out_m2), m2);
    chk({"R4 m ", name}, 64'(out_m), m);
    chk({"R5 mf ", name}, 64'(out_mf), mf);
    chk({"R5 warn ", name}, 64'(out_warn), warn);
    chk({"R6 dco ", name}, 64'(out_dco), dco & MSK);
    chk({"R6 clkout ", name}, 64'(out_clkout), cko);
    chk({"R7 sd ", name}, 64'(out_sd), sd);
    chk({"R8 cfg1 ", name}, 64'(out_cfg1), ((m & 12'hFFF) << 9) | (((n - 1) & 8'hFF) << 1));
    chk({"R8 cfg3 ", name}, 64'(out_cfg3), (sd & 8'hFF) << 10);
    chk({"R8 cfg4 ", name}, 64'(out_cfg4), ((m2 & 7'h7F) << 18) | mf);
    chk({"R9 cfg2 ", name}, 64'(out_cfg2), sel << 1);
    @(negedge clk);
    chk({"R11 pulse dropped ", name}, 64'(out_valid), 0);
    chk({"R11 results held ", name}, 64'(out_m), m);
  endtask

  initial begin
    t_reset();
    run_case("typical", 19_200_000, 148_500_000, 1'b0);
    run_case("odd fint", 26_000_000, 25_175_000, 1'b0);
    run_case("m2 one high band", 38_400_000, 1_200_000_000, 1'b0);
    run_case("exact n boundary", 2_500_000, 100_000_000, 1'b0);
    run_case("band threshold equal", 2_500_000, 1_000_000_000, 1'b0);
    run_case("saturated m warn", 1_000, 100_000_000, 1'b0);
    run_case("fractional mid", 12_000_000, 7_000_001, 1'b0);
    run_case("busy ignore", 19_200_000, 148_500_000, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule